// File: doc/BRIEF.md
# Timestamp Event Capture Interrupt Unit

This unit observes a free-running system time value that is counted elsewhere, and records a copy of that value when a trigger occurs. There are four triggers: two asynchronous event pins, a transmit strobe for timing frames and a receive strobe for timing frames. Each trigger has its own 64-bit snapshot register. The unit also holds two programmable target times and reports when the system time reaches either of them.

Every cause owns a sticky pending flag in one 16-bit event register. Software acknowledges a cause by writing a one to its flag. A snapshot register does not change while its flag is set. Software therefore reads a captured time that no later trigger can overwrite, and then acknowledges it. A mask register selects which pending flags drive the single active-low host interrupt.

All state is reached through a small word-wide register bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `tsu_event_capture`

## Requirements
- R1: The mask register is at word address 0x00 and the event register is at 0x02. Both use the same bit positions: bit 0 target-1 match, bit 1 target-2 match, bit 2 event-1 capture, bit 3 event-2 capture, bit 4 transmit capture, bit 5 receive capture. Bits 15..6 of both read as zero, and any unmapped address reads zero.
- R2: After reset all six flags and all mask bits are zero, and `host_irq_n` is high.
- R3: A rising edge on `ext_evt1` passes a two-flop synchronizer and an edge detector. It then stores `sys_time` in the event-1 snapshot and sets flag bit 2. `ext_evt2` does the same into its own snapshot and sets flag bit 3. The snapshots are at addresses 0x08..0x0B (event 1) and 0x0C..0x0F (event 2), with the least significant word at the lowest address.
- R4: While an event flag is set, further rising edges on that pin leave its snapshot and its flag unchanged.
- R5: A one-cycle `tx_frame_stb` pulse stores `sys_time` in the transmit snapshot (0x10..0x13) and sets bit 4. `rx_frame_stb` does the same into the receive snapshot (0x14..0x17) and sets bit 5. A strobe is ignored while its own flag is set.
- R6: The target registers are at 0x18..0x1B (target 1) and 0x1C..0x1F (target 2). They can be read and written, and they reset to all ones. A cycle in which `sys_time` equals a target sets that target's flag.
- R7: Writing a one to an event-register bit clears that flag. Writing a zero to a bit leaves that flag unchanged.
- R8: `host_irq_n` is low exactly when some flag is set and its mask bit is one. A zero mask bit keeps that cause from asserting the interrupt.
- R9: If a trigger and a write-one-to-clear of the same flag fall in the same cycle, the trigger wins. The flag stays set and the snapshot takes the new time.
- R10: A target flag is set once per match episode. If the flag is cleared while the time still equals the target, the flag stays clear. A later, separate equality sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_time | input | 64 | Current system time value |
| ext_evt1 | input | 1 | Asynchronous event pin 1 |
| ext_evt2 | input | 1 | Asynchronous event pin 2 |
| tx_frame_stb | input | 1 | Transmit timing-frame strobe, one cycle |
| rx_frame_stb | input | 1 | Receive timing-frame strobe, one cycle |
| bus_addr | input | 6 | Word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| host_irq_n | output | 1 | Active-low host interrupt |

## Verification
A capture trigger and a software acknowledge of the same flag can land in the same clock cycle. The bench provokes this on the transmit path. With the flag already set, it drives `tx_frame_stb`, a new `sys_time` value and a write-one-to-clear of bit 4 on the same negative edge. It then confirms that the flag is still set and that the snapshot holds the new time rather than the old one. A second case of the same kind concerns a target time. The bench clears the target flag while the time still equals the target, and the flag must stay clear until the time moves away and comes back.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
   localparam int NUM_FLAGS = 6;
   localparam int NUM_SNAP  = 4;
   localparam int NUM_TGT   = 2;

   // flag positions in mask and event registers
   localparam int FLG_TT1 = 0;
   localparam int FLG_TT2 = 1;
   localparam int FLG_EV1 = 2;
   localparam int FLG_EV2 = 3;
   localparam int FLG_TX  = 4;
   localparam int FLG_RX  = 5;

   // absolute word addresses of control registers
   localparam int MASK_ADDR = 0;
   localparam int EVT_ADDR  = 2;

   // block numbers (address bits above the word select)
   localparam int BLK_SNAP0 = 2;   // ev1, ev2, tx, rx follow in order
   localparam int BLK_TGT0  = 6;   // tgt1, tgt2 follow in order
endpackage

// File: rtl/tsu_edge_sync.sv
module tsu_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tsu_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tsu_snap_chan.sv
module tsu_snap_chan #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic              clr,
   input  logic [TIME_W-1:0] t_in,
   output logic              pend,
   output logic [TIME_W-1:0] snap
);
   logic take;

   // a trigger is taken when the slot is free or being freed this cycle
   assign take = trig & (~pend | clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         snap <= '0;
      end else if (take) begin
         pend <= 1'b1;
         snap <= t_in;
      end else if (clr) begin
         pend <= 1'b0;
      end
   end
endmodule

// File: rtl/tsu_target_cmp.sv
module tsu_target_cmp #(
   parameter int TIME_W = 64,
   parameter int WORD_W = 16,
   parameter int WSEL_W = $clog2(TIME_W / WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              clr,
   input  logic [TIME_W-1:0] sys_time,
   output logic              pend,
   output logic [TIME_W-1:0] target
);
   localparam int WORDS = TIME_W / WORD_W;

   logic hit, hit_q, set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target <= '1;
      end else if (wr_en) begin
         for (int w = 0; w < WORDS; w++) begin
            if (wr_word == WSEL_W'(w)) target[w*WORD_W +: WORD_W] <= wr_data;
         end
      end
   end

   assign hit = (sys_time == target);
   assign set = hit & ~hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         pend  <= 1'b0;
      end else begin
         hit_q <= hit;
         if (set)      pend <= 1'b1;
         else if (clr) pend <= 1'b0;
      end
   end
endmodule

// File: rtl/tsu_event_capture.sv
module tsu_event_capture
   import tsu_pkg::*;
#(
   parameter int TIME_W      = 64,
   parameter int WORD_W      = 16,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] sys_time,
   input  logic              ext_evt1,
   input  logic              ext_evt2,
   input  logic              tx_frame_stb,
   input  logic              rx_frame_stb,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              host_irq_n
);
   localparam int WORDS  = TIME_W / WORD_W;
   localparam int WSEL_W = $clog2(WORDS);
   localparam int BLK_W  = ADDR_W - WSEL_W;

   if (TIME_W % WORD_W != 0 || (1 << WSEL_W) != WORDS) begin : g_bad_words
      $error("tsu_event_capture: TIME_W must be a power-of-two multiple of WORD_W");
   end
   if (BLK_W < 3) begin : g_bad_addr
      $error("tsu_event_capture: ADDR_W too small for eight register blocks");
   end
   if (WORD_W < NUM_FLAGS) begin : g_bad_word
      $error("tsu_event_capture: WORD_W narrower than flag field");
   end

   logic [BLK_W-1:0]                   blk;
   logic [WSEL_W-1:0]                  wsel;
   logic [NUM_FLAGS-1:0]               mask_q, clr_vec, flags;
   logic [NUM_SNAP-1:0]                trig, snap_pend;
   logic [NUM_SNAP-1:0][TIME_W-1:0]    snap_q;
   logic [NUM_TGT-1:0]                 tgt_pend;
   logic [NUM_TGT-1:0][TIME_W-1:0]     tgt_q;
   logic [1:0]                         ext_pins, ext_rise;
   logic                               evt_wr;

   assign blk  = bus_addr[ADDR_W-1:WSEL_W];
   assign wsel = bus_addr[WSEL_W-1:0];

   // ---------------- mask and write-one-to-clear ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                           mask_q <= '0;
      else if (bus_we && bus_addr == ADDR_W'(MASK_ADDR))    mask_q <= bus_wdata[NUM_FLAGS-1:0];
   end

   assign evt_wr  = bus_we && (bus_addr == ADDR_W'(EVT_ADDR));
   assign clr_vec = evt_wr ? bus_wdata[NUM_FLAGS-1:0] : '0;

   // ---------------- trigger sources ----------------
   assign ext_pins = {ext_evt2, ext_evt1};

   for (genvar e = 0; e < 2; e++) begin : g_sync
      tsu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (ext_pins[e]),
         .rise     (ext_rise[e])
      );
   end

   assign trig = {rx_frame_stb, tx_frame_stb, ext_rise};

   // ---------------- snapshot channels ----------------
   for (genvar c = 0; c < NUM_SNAP; c++) begin : g_snap
      tsu_snap_chan #(.TIME_W(TIME_W)) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .trig  (trig[c]),
         .clr   (clr_vec[FLG_EV1 + c]),
         .t_in  (sys_time),
         .pend  (snap_pend[c]),
         .snap  (snap_q[c])
      );
   end

   // ---------------- target comparators ----------------
   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      logic tgt_wr;
      assign tgt_wr = bus_we && (blk == BLK_W'(BLK_TGT0 + t));
      tsu_target_cmp #(.TIME_W(TIME_W), .WORD_W(WORD_W), .WSEL_W(WSEL_W)) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (tgt_wr),
         .wr_word  (wsel),
         .wr_data  (bus_wdata),
         .clr      (clr_vec[FLG_TT1 + t]),
         .sys_time (sys_time),
         .pend     (tgt_pend[t]),
         .target   (tgt_q[t])
      );
   end

   assign flags = {snap_pend, tgt_pend};

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(MASK_ADDR)) begin
         bus_rdata[NUM_FLAGS-1:0] = mask_q;
      end else if (bus_addr == ADDR_W'(EVT_ADDR)) begin
         bus_rdata[NUM_FLAGS-1:0] = flags;
      end else begin
         for (int c = 0; c < NUM_SNAP; c++) begin
            if (blk == BLK_W'(BLK_SNAP0 + c))
               bus_rdata = snap_q[c][int'(wsel)*WORD_W +: WORD_W];
         end
         for (int t = 0; t < NUM_TGT; t++) begin
            if (blk == BLK_W'(BLK_TGT0 + t))
               bus_rdata = tgt_q[t][int'(wsel)*WORD_W +: WORD_W];
         end
      end
   end

   // ---------------- interrupt ----------------
   assign host_irq_n = ~|(flags & mask_q);
endmodule

// File: rtl/tsu_event_capture_chk.sv
module tsu_event_capture_chk
   import tsu_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int WORD_W = 16,
   parameter int ADDR_W = 6
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [ADDR_W-1:0]               bus_addr,
   input logic [WORD_W-1:0]               bus_rdata,
   input logic                            host_irq_n,
   input logic [NUM_FLAGS-1:0]            flags,
   input logic [NUM_FLAGS-1:0]            mask,
   input logic [NUM_FLAGS-1:0]            clr,
   input logic [NUM_SNAP-1:0]             trig,
   input logic [NUM_SNAP-1:0][TIME_W-1:0] snap,
   input logic [NUM_TGT-1:0][TIME_W-1:0]  tgt,
   input logic [TIME_W-1:0]               sys_time
);
   // R1: unused event-register bits read zero
   a_r1_evt_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(EVT_ADDR)) |-> (bus_rdata[WORD_W-1:NUM_FLAGS] == '0));

   // R8: all causes masked keeps interrupt idle
   a_r8_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> host_irq_n);

   // R8: nothing pending keeps interrupt idle
   a_r8_no_pend_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> host_irq_n);

   for (genvar c = 0; c < NUM_SNAP; c++) begin : g_chan
      // R3 / R5: free slot captures time and sets flag
      a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
         (trig[c] && !flags[FLG_EV1 + c]) |=>
            (flags[FLG_EV1 + c] && snap[c] == $past(sys_time)));

      // R4 / R5: snapshot frozen while flag set and not cleared
      a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[FLG_EV1 + c] && !clr[FLG_EV1 + c]) |=>
            ($stable(snap[c]) && flags[FLG_EV1 + c]));

      // R9: trigger beats clear in the same cycle
      a_r9_trig_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (trig[c] && clr[FLG_EV1 + c]) |=>
            (flags[FLG_EV1 + c] && snap[c] == $past(sys_time)));

      // R7: clear without trigger drops flag
      a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[FLG_EV1 + c] && !trig[c]) |=> !flags[FLG_EV1 + c]);
   end

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      // R6: a target flag rises only after an equality
      a_r6_match_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flags[FLG_TT1 + t]) |-> $past(sys_time == tgt[t]));
   end
endmodule

bind tsu_event_capture tsu_event_capture_chk #(
   .TIME_W (TIME_W),
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .host_irq_n (host_irq_n),
   .flags      (flags),
   .mask       (mask_q),
   .clr        (clr_vec),
   .trig       (trig),
   .snap       (snap_q),
   .tgt        (tgt_q),
   .sys_time   (sys_time)
);

// File: tb/tsu_event_capture_tb_top.sv
module tsu_event_capture_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] sys_time = '0;
   logic        ext_evt1 = 1'b0, ext_evt2 = 1'b0;
   logic        tx_frame_stb = 1'b0, rx_frame_stb = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        host_irq_n;

   int n_checks = 0;
   int n_fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   tsu_event_capture dut_i (
      .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
      .ext_evt1(ext_evt1), .ext_evt2(ext_evt2),
      .tx_frame_stb(tx_frame_stb), .rx_frame_stb(rx_frame_stb),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .host_irq_n(host_irq_n)
   );

   // {write, addr[5:0], data[15:0], expected[15:0]}
   localparam logic [38:0] VEC [0:13] = '{
      {1'b0, 6'h18, 16'h0000, 16'hFFFF},   // R6 target reset value
      {1'b1, 6'h00, 16'h003F, 16'h0000},   // R1 mask write
      {1'b0, 6'h00, 16'h0000, 16'h003F},
      {1'b1, 6'h00, 16'hFFC0, 16'h0000},
      {1'b0, 6'h00, 16'h0000, 16'h0000},   // R1 upper mask bits dropped
      {1'b1, 6'h02, 16'hFFFF, 16'h0000},
      {1'b0, 6'h02, 16'h0000, 16'h0000},   // R7 clear on empty register
      {1'b1, 6'h1C, 16'h1111, 16'h0000},
      {1'b1, 6'h1D, 16'h2222, 16'h0000},
      {1'b1, 6'h1E, 16'h3333, 16'h0000},
      {1'b1, 6'h1F, 16'h4444, 16'h0000},
      {1'b0, 6'h1C, 16'h0000, 16'h1111},   // R6 target readback
      {1'b0, 6'h1F, 16'h0000, 16'h4444},
      {1'b0, 6'h07, 16'h0000, 16'h0000}    // R1 unmapped reads zero
   };

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic rd64(input logic [5:0] base, output logic [63:0] v);
      logic [15:0] w;
      for (int i = 0; i < 4; i++) begin
         rd(base + 6'(i), w);
         v[i*16 +: 16] = w;
      end
   endtask

   task automatic pulse_evt(input int which);
      @(negedge clk);
      if (which == 1) ext_evt1 = 1'b1; else ext_evt2 = 1'b1;
      repeat (4) @(negedge clk);
      ext_evt1 = 1'b0; ext_evt2 = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic strobe(input int rx);
      @(negedge clk);
      if (rx != 0) rx_frame_stb = 1'b1; else tx_frame_stb = 1'b1;
      @(negedge clk);
      rx_frame_stb = 1'b0; tx_frame_stb = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [15:0] r;
      logic [63:0] v;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      check("R2 irq idle", 64'(host_irq_n), 64'd1);
      rd(6'h02, r); check("R2 flags zero", 64'(r), 64'h0);
      rd(6'h00, r); check("R2 mask zero", 64'(r), 64'h0);

      // table walk
      foreach (VEC[i]) begin
         if (VEC[i][38]) wr(VEC[i][37:32], VEC[i][31:16]);
         else begin
            rd(VEC[i][37:32], r);
            check($sformatf("table vector %0d", i), 64'(r), 64'(VEC[i][15:0]));
         end
      end

      // R3 event-1 capture
      sys_time = 64'h0123_4567_89AB_CDEF;
      pulse_evt(1);
      rd(6'h02, r); check("R3 ev1 flag", 64'(r), 64'h0004);
      rd64(6'h08, v); check("R3 ev1 snapshot", v, 64'h0123_4567_89AB_CDEF);

      // R4 later edge ignored while flag set
      sys_time = 64'h5555_0000_AAAA_0001;
      pulse_evt(1);
      rd64(6'h08, v); check("R4 ev1 frozen", v, 64'h0123_4567_89AB_CDEF);
      rd(6'h02, r); check("R4 ev1 flag kept", 64'(r), 64'h0004);

      // R7 clear by writing one
      wr(6'h02, 16'h0004);
      rd(6'h02, r); check("R7 ev1 cleared", 64'(r), 64'h0);

      // R3 event-2
      sys_time = 64'h0000_1111_2222_3333;
      pulse_evt(2);
      rd(6'h02, r); check("R3 ev2 flag", 64'(r), 64'h0008);
      rd64(6'h0C, v); check("R3 ev2 snapshot", v, 64'h0000_1111_2222_3333);

      // R7 zero write leaves flag
      wr(6'h02, 16'h0000);
      rd(6'h02, r); check("R7 zero write keeps", 64'(r), 64'h0008);
      wr(6'h02, 16'h0008);

      // R5 transmit capture and hold
      sys_time = 64'hAAAA_BBBB_CCCC_DDDD;
      strobe(0);
      rd(6'h02, r); check("R5 tx flag", 64'(r), 64'h0010);
      rd64(6'h10, v); check("R5 tx snapshot", v, 64'hAAAA_BBBB_CCCC_DDDD);
      sys_time = 64'h1;
      strobe(0);
      rd64(6'h10, v); check("R5 tx frozen", v, 64'hAAAA_BBBB_CCCC_DDDD);

      // R8 masking
      check("R8 masked irq idle", 64'(host_irq_n), 64'd1);
      wr(6'h00, 16'h0010);
      check("R8 irq asserted", 64'(host_irq_n), 64'd0);
      wr(6'h00, 16'h0020);
      check("R8 other mask idle", 64'(host_irq_n), 64'd1);

      // R9 trigger and clear in the same cycle
      @(negedge clk);
      sys_time = 64'h7777_6666_5555_4444;
      tx_frame_stb = 1'b1;
      bus_addr = 6'h02; bus_wdata = 16'h0010; bus_we = 1'b1;
      @(negedge clk);
      tx_frame_stb = 1'b0; bus_we = 1'b0;
      rd(6'h02, r); check("R9 flag stays", 64'(r), 64'h0010);
      rd64(6'h10, v); check("R9 new snapshot", v, 64'h7777_6666_5555_4444);

      // R5 receive path, R8 with rx mask
      sys_time = 64'h0BAD_F00D_0000_0042;
      strobe(1);
      rd(6'h02, r); check("R5 rx flag", 64'(r), 64'h0030);
      rd64(6'h14, v); check("R5 rx snapshot", v, 64'h0BAD_F00D_0000_0042);
      check("R8 rx irq", 64'(host_irq_n), 64'd0);
      wr(6'h02, 16'h0030);
      rd(6'h02, r); check("R7 both cleared", 64'(r), 64'h0);
      check("R8 irq released", 64'(host_irq_n), 64'd1);

      // R6 target match
      wr(6'h18, 16'h0500); wr(6'h19, 16'h0000);
      wr(6'h1A, 16'h0000); wr(6'h1B, 16'h0000);
      rd(6'h02, r); check("R6 no early match", 64'(r), 64'h0);
      wr(6'h00, 16'h0001);
      @(negedge clk);
      sys_time = 64'h500;
      @(negedge clk);
      rd(6'h02, r); check("R6 target1 flag", 64'(r), 64'h0001);
      check("R8 target irq", 64'(host_irq_n), 64'd0);

      // R10 clear during ongoing equality stays clear
      repeat (2) @(negedge clk);
      wr(6'h02, 16'h0001);
      repeat (2) @(negedge clk);
      rd(6'h02, r); check("R10 once per match", 64'(r), 64'h0);
      sys_time = 64'h501;
      @(negedge clk);
      sys_time = 64'h500;
      @(negedge clk);
      rd(6'h02, r); check("R10 rematch sets", 64'(r), 64'h0001);
      wr(6'h02, 16'h0001);
      sys_time = 64'h9000;
      @(negedge clk);
      rd(6'h02, r); check("R7 target cleared", 64'(r), 64'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule